// File: doc/BRIEF.md
# ISA Slave Access Decoder

This block sits between the host ISA bus and the internal logic of a network adapter. It turns host bus cycles into select strobes for three address windows: a 32-byte I/O register window, a shared packet-memory window and a boot ROM window. The low address bits come from the latched address bus. They pass through while the address-latch enable is high and are held once it falls. The high address bits from the unlatched bus are captured at that same falling edge.

A data-width strap picks the strobe set for the packet-memory window. With the strap high (16-bit slot), the full-range memory strobes are used. With the strap low (8-bit slot), the strobes that only fire below 1 MB are used. The block also produces the signals the bus needs back from the adapter:
- the 16-bit memory and 16-bit I/O indications,
- a byte-lane enable pair and an odd-to-low byte steering flag,
- a channel-ready hold request that adds a fixed number of wait cycles at the start of each access.

All open-collector bus outputs come out as active-high "pull low" requests. The pad cells turn them into drive. All bus inputs are treated as active-high levels that are already synchronous to `clk`.

Top module: `isa_slave_decode`

## Requirements
- R1: The low address used for decoding follows `sa` in the same cycle while `bale` is high. Once `bale` is low, it is the value `sa` had on the last clock edge with `bale` high, and later changes on `sa` have no effect on any select.
- R2: The high address `la` (bits 23:17) is captured on every clock edge with `bale` high and held while `bale` is low. Later changes on `la` have no effect on any memory decode.
- R3: `ioRdSel`/`ioWrSel` are high exactly when the decoded address bits 9:5 equal `ioBaseCfg`, the matching I/O strobe is high and `aen` is low. While `aen` is high, both stay low.
- R4: The memory window is hit when address bits 23:14 (the held `la` above the decoded `sa[16:14]`) equal `memBaseCfg`. With `wide16` high, `memRdSel`/`memWrSel` follow `memRd`/`memWr` and ignore the low-memory strobes. With `wide16` low, they follow `lowMemRd`/`lowMemWr` and ignore `memRd`/`memWr`.
- R5: `romRdSel` is high when `sa` bits 19:14 equal `romBaseCfg` and `lowMemRd` is high, in either width mode. It is never raised by `memRd` or by any write strobe. When the memory window also hits, the memory window wins and `romRdSel` stays low.
- R6: `mem16Pull` is high exactly when `wide16` is high and the held `la` equals `memBaseCfg` bits 9:3, so it covers the whole 128 KB region. It needs no strobe, and it is never high in 8-bit mode.
- R7: `io16Pull` is high exactly when an I/O select is active, `wide16` is high, address bit 0 is 0 and `hostHighEn` is high.
- R8: With no select active, `laneEn` is 2'b00. With a select active in 8-bit mode, `laneEn`=2'b01 and `oddToLow` equals address bit 0. With a select active in 16-bit mode, {A0,hostHighEn} sets the lanes as follows:
  - 00 gives `laneEn`=01 and `oddToLow`=0.
  - 01 gives `laneEn`=11 and `oddToLow`=0.
  - 10 gives `laneEn`=01 and `oddToLow`=1.
  - 11 gives `laneEn`=10 and `oddToLow`=0.
- R9: `chrdyPull` is high for exactly `WAIT_CYC` cycles (default 3). The count starts with the cycle in which some select goes high after a cycle with none. A select held longer does not extend it. Another access starts the count again only after all selects have been low for a cycle.
- R10: After `busReset`, the held address and captured high address are zero, no select is active and `chrdyPull` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all bus inputs sampled against it |
| busReset | input | 1 | Synchronous active-high reset from the bus |
| bale | input | 1 | Address-latch enable |
| sa | input | 20 | Latched low address bus |
| la | input | 7 | Unlatched high address bits 23:17 |
| hostHighEn | input | 1 | Host wants the upper byte lane |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| memRd | input | 1 | Full-range memory read strobe |
| memWr | input | 1 | Full-range memory write strobe |
| lowMemRd | input | 1 | Below-1MB memory read strobe |
| lowMemWr | input | 1 | Below-1MB memory write strobe |
| aen | input | 1 | A DMA controller owns the bus |
| wide16 | input | 1 | Data-width strap, high for a 16-bit slot |
| ioBaseCfg | input | 5 | I/O window base, address bits 9:5 |
| memBaseCfg | input | 10 | Memory window base, address bits 23:14 |
| romBaseCfg | input | 6 | Boot ROM window base, address bits 19:14 |
| ioRdSel | output | 1 | Register-file read select |
| ioWrSel | output | 1 | Register-file write select |
| memRdSel | output | 1 | Packet-memory read select |
| memWrSel | output | 1 | Packet-memory write select |
| romRdSel | output | 1 | Boot ROM read select |
| laneEn | output | 2 | Byte lanes in use: bit 0 low lane, bit 1 high lane |
| oddToLow | output | 1 | Odd byte is steered onto the low lane |
| mem16Pull | output | 1 | Pull request for the 16-bit memory indication |
| io16Pull | output | 1 | Pull request for the 16-bit I/O indication |
| chrdyPull | output | 1 | Pull request holding channel-ready low (wait state) |

## Verification
The bench changes `sa` and `la` after the latch enable falls and before every strobe. A decoder that reads the live buses instead of the held values would then select the wrong window. Every low-memory and full-range strobe is tried in both width modes. A wrong strobe set shows up as a select when the strap should block it, or no select when it should pass. The bench also places the ROM window inside the memory window, where a wrong priority raises both selects. It walks the four lane cases in each width mode, and it counts the wait cycles. A counter off by one, or one that restarts while a select is held, gives the wrong number of pull-low cycles.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

  // Capture strobes from the control to the datapath
  typedef struct packed {
    logic trackLow;   // low address follows the bus
    logic trackHigh;  // high address is being captured
  } capCtl_t;

  // Window compare results from the datapath to the control
  typedef struct packed {
    logic ioHit;
    logic memHit;
    logic romHit;
    logic region;     // captured high address inside the 128 KB region
    logic addr0;      // decoded address bit 0
  } winHit_t;

endpackage

// File: rtl/isa_dec_datapath.sv
module isa_dec_datapath
  import isa_dec_pkg::*;
#(
  parameter int SA_W         = 20,
  parameter int LA_W         = 7,
  parameter int ADDR_W       = 24,
  parameter int IO_AW        = 10,
  parameter int IO_WIN_BITS  = 5,
  parameter int MEM_WIN_BITS = 14,
  parameter int ROM_WIN_BITS = 14
) (
  input  logic                             clk,
  input  logic                             rst,
  input  capCtl_t                          ctl,
  input  logic [SA_W-1:0]                  sa,
  input  logic [LA_W-1:0]                  la,
  input  logic [IO_AW-IO_WIN_BITS-1:0]     ioBase,
  input  logic [ADDR_W-MEM_WIN_BITS-1:0]   memBase,
  input  logic [SA_W-ROM_WIN_BITS-1:0]     romBase,
  output winHit_t                          hit
);

  localparam int LA_LO  = ADDR_W - LA_W;
  localparam int MEMB_W = ADDR_W - MEM_WIN_BITS;

  logic [SA_W-1:0]   saHeld;
  logic [LA_W-1:0]   laHeld;
  logic [SA_W-1:0]   saEff;
  logic [ADDR_W-1:0] memAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      saHeld <= '0;
      laHeld <= '0;
    end else begin
      if (ctl.trackLow)  saHeld <= sa;
      if (ctl.trackHigh) laHeld <= la;
    end
  end

  // Transparent while the latch enable is high
  assign saEff   = ctl.trackLow ? sa : saHeld;
  assign memAddr = {laHeld, saEff[LA_LO-1:0]};

  assign hit.ioHit  = (saEff[IO_AW-1:IO_WIN_BITS] == ioBase);
  assign hit.memHit = (memAddr[ADDR_W-1:MEM_WIN_BITS] == memBase);
  assign hit.romHit = (saEff[SA_W-1:ROM_WIN_BITS] == romBase);
  assign hit.region = (laHeld == memBase[MEMB_W-1 -: LA_W]);
  assign hit.addr0  = saEff[0];

  // R1: held low address only moves while tracking
  a_r1_low_held: assert property (@(posedge clk) disable iff (rst)
    !ctl.trackLow |=> $stable(saHeld));

  // R2: captured high address frozen outside the latch window
  a_r2_high_held: assert property (@(posedge clk) disable iff (rst)
    !ctl.trackHigh |=> $stable(laHeld));

endmodule

// File: rtl/isa_dec_control.sv
module isa_dec_control
  import isa_dec_pkg::*;
#(
  parameter int WAIT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bale,
  input  logic       ioRd,
  input  logic       ioWr,
  input  logic       memRd,
  input  logic       memWr,
  input  logic       lowMemRd,
  input  logic       lowMemWr,
  input  logic       aen,
  input  logic       wide16,
  input  logic       hostHighEn,
  input  winHit_t    hit,
  output capCtl_t    ctl,
  output logic       ioRdSel,
  output logic       ioWrSel,
  output logic       memRdSel,
  output logic       memWrSel,
  output logic       romRdSel,
  output logic [1:0] laneEn,
  output logic       oddToLow,
  output logic       mem16Pull,
  output logic       io16Pull,
  output logic       chrdyPull
);

  logic memStbRd, memStbWr;
  logic anySel, anySelQ, selRise, ioSel;

  assign ctl.trackLow  = bale;
  assign ctl.trackHigh = bale;

  // Strobe set chosen by the width strap
  assign memStbRd = wide16 ? memRd : lowMemRd;
  assign memStbWr = wide16 ? memWr : lowMemWr;

  assign ioRdSel  = hit.ioHit & ioRd & ~aen;
  assign ioWrSel  = hit.ioHit & ioWr & ~aen;
  assign memRdSel = hit.memHit & memStbRd;
  assign memWrSel = hit.memHit & memStbWr;
  assign romRdSel = hit.romHit & ~hit.memHit & lowMemRd;

  assign ioSel  = ioRdSel | ioWrSel;
  assign anySel = ioSel | memRdSel | memWrSel | romRdSel;

  // Byte-lane steering
  always_comb begin
    laneEn   = 2'b00;
    oddToLow = 1'b0;
    if (anySel) begin
      if (!wide16) begin
        laneEn   = 2'b01;
        oddToLow = hit.addr0;
      end else begin
        unique case ({hit.addr0, hostHighEn})
          2'b00: laneEn = 2'b01;
          2'b01: laneEn = 2'b11;
          2'b10: begin laneEn = 2'b01; oddToLow = 1'b1; end
          default: laneEn = 2'b10;
        endcase
      end
    end
  end

  assign mem16Pull = wide16 & hit.region;
  assign io16Pull  = ioSel & wide16 & ~hit.addr0 & hostHighEn;

  always_ff @(posedge clk) begin
    if (rst) anySelQ <= 1'b0;
    else     anySelQ <= anySel;
  end

  assign selRise = anySel & ~anySelQ;

  generate
    if (WAIT_CYC > 0) begin : g_wait
      localparam int CW = $clog2(WAIT_CYC + 1);
      logic [CW-1:0] waitCnt;

      always_ff @(posedge clk) begin
        if (rst)                 waitCnt <= '0;
        else if (selRise)        waitCnt <= CW'(WAIT_CYC - 1);
        else if (waitCnt != '0)  waitCnt <= waitCnt - CW'(1);
      end

      assign chrdyPull = selRise | (waitCnt != '0);

      // R9: counter never exceeds the remaining wait budget
      a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        waitCnt <= CW'(WAIT_CYC - 1));
      // R9: every new access starts with a wait request
      a_r9_wait_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(anySel) |-> chrdyPull);
    end else begin : g_nowait
      assign chrdyPull = 1'b0;
    end
  endgenerate

  // R5: memory window wins over boot ROM
  a_r5_mem_over_rom: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRdSel, romRdSel}));

  // R8: no lanes without a select
  a_r8_lanes_need_sel: assert property (@(posedge clk) disable iff (rst)
    (laneEn != 2'b00) |-> anySel);

  // R7: 16-bit I/O indication implies a full word on both lanes
  a_r7_io16_word: assert property (@(posedge clk) disable iff (rst)
    io16Pull |-> (ioSel && laneEn == 2'b11));

endmodule

// File: rtl/isa_slave_decode.sv
module isa_slave_decode
  import isa_dec_pkg::*;
#(
  parameter int WAIT_CYC = 3
) (
  input  logic        clk,
  input  logic        busReset,
  input  logic        bale,
  input  logic [19:0] sa,
  input  logic [6:0]  la,
  input  logic        hostHighEn,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic        memRd,
  input  logic        memWr,
  input  logic        lowMemRd,
  input  logic        lowMemWr,
  input  logic        aen,
  input  logic        wide16,
  input  logic [4:0]  ioBaseCfg,
  input  logic [9:0]  memBaseCfg,
  input  logic [5:0]  romBaseCfg,
  output logic        ioRdSel,
  output logic        ioWrSel,
  output logic        memRdSel,
  output logic        memWrSel,
  output logic        romRdSel,
  output logic [1:0]  laneEn,
  output logic        oddToLow,
  output logic        mem16Pull,
  output logic        io16Pull,
  output logic        chrdyPull
);

  capCtl_t ctl;
  winHit_t hit;

  isa_dec_datapath #(
    .SA_W(20), .LA_W(7), .ADDR_W(24), .IO_AW(10),
    .IO_WIN_BITS(5), .MEM_WIN_BITS(14), .ROM_WIN_BITS(14)
  ) u_dp (
    .clk(clk), .rst(busReset), .ctl(ctl), .sa(sa), .la(la),
    .ioBase(ioBaseCfg), .memBase(memBaseCfg), .romBase(romBaseCfg),
    .hit(hit)
  );

  isa_dec_control #(.WAIT_CYC(WAIT_CYC)) u_ctl (
    .clk(clk), .rst(busReset), .bale(bale),
    .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd), .memWr(memWr),
    .lowMemRd(lowMemRd), .lowMemWr(lowMemWr), .aen(aen),
    .wide16(wide16), .hostHighEn(hostHighEn), .hit(hit), .ctl(ctl),
    .ioRdSel(ioRdSel), .ioWrSel(ioWrSel), .memRdSel(memRdSel),
    .memWrSel(memWrSel), .romRdSel(romRdSel), .laneEn(laneEn),
    .oddToLow(oddToLow), .mem16Pull(mem16Pull), .io16Pull(io16Pull),
    .chrdyPull(chrdyPull)
  );

endmodule

// File: tb/isa_slave_decode_bench.sv
module isa_slave_decode_bench;

  logic clk = 1'b0;
  logic busReset, bale, hostHighEn, ioRd, ioWr, memRd, memWr;
  logic lowMemRd, lowMemWr, aen, wide16;
  logic [19:0] sa;
  logic [6:0]  la;
  logic [4:0]  ioBaseCfg;
  logic [9:0]  memBaseCfg;
  logic [5:0]  romBaseCfg;
  logic ioRdSel, ioWrSel, memRdSel, memWrSel, romRdSel, oddToLow;
  logic mem16Pull, io16Pull, chrdyPull;
  logic [1:0] laneEn;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  isa_slave_decode u_isa_slave_decode (
    .clk(clk), .busReset(busReset), .bale(bale), .sa(sa), .la(la),
    .hostHighEn(hostHighEn), .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd),
    .memWr(memWr), .lowMemRd(lowMemRd), .lowMemWr(lowMemWr), .aen(aen),
    .wide16(wide16), .ioBaseCfg(ioBaseCfg), .memBaseCfg(memBaseCfg),
    .romBaseCfg(romBaseCfg), .ioRdSel(ioRdSel), .ioWrSel(ioWrSel),
    .memRdSel(memRdSel), .memWrSel(memWrSel), .romRdSel(romRdSel),
    .laneEn(laneEn), .oddToLow(oddToLow), .mem16Pull(mem16Pull),
    .io16Pull(io16Pull), .chrdyPull(chrdyPull)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Address phase, then scramble both buses (R1, R2)
  task automatic capture(input logic [19:0] a, input logic [6:0] l);
    @(negedge clk);
    bale = 1'b1; sa = a; la = l;
    @(negedge clk);
    bale = 1'b0; sa = ~a; la = ~l;
    @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    busReset = 1'b1; bale = 0; hostHighEn = 0; ioRd = 0; ioWr = 0;
    memRd = 0; memWr = 0; lowMemRd = 0; lowMemWr = 0; aen = 0; wide16 = 0;
    sa = '0; la = '0; ioBaseCfg = '0; memBaseCfg = '0; romBaseCfg = '0;
    repeat (3) @(negedge clk);
    busReset = 1'b0;
    #1;
    // R10: reset state
    check("R10 no select", {ioRdSel, ioWrSel, memRdSel, memWrSel, romRdSel}, 0);
    check("R10 chrdy", chrdyPull, 0);
    ioRd = 1'b1; #1;
    check("R10 held addr zero", ioRdSel, 1);
    ioRd = 1'b0;

    ioBaseCfg = 5'h0A; romBaseCfg = 6'h3C; memBaseCfg = 10'h0C8; wide16 = 1'b1;

    // R1: transparent while bale is high
    @(negedge clk);
    bale = 1'b1; sa = 20'h00140; ioRd = 1'b1; #1;
    check("R1 transparent hit", ioRdSel, 1);
    sa = 20'h00100; #1;
    check("R1 transparent miss", ioRdSel, 0);
    ioRd = 1'b0;
    @(negedge clk); bale = 1'b0;

    // R3 with R1: full sweep of the 10-bit I/O space
    for (int a = 0; a < 1024; a++) begin
      logic expHit;
      capture(20'(a), 7'h00);
      expHit = (a[9:5] == 5'h0A);
      aen = 1'b0; ioRd = 1'b1; #1;
      check("R3 io read", ioRdSel, expHit);
      ioRd = 1'b0; ioWr = 1'b1; #1;
      check("R3 io write", ioWrSel, expHit);
      aen = 1'b1; #1;
      check("R3 aen blocks write", ioWrSel, 0);
      ioWr = 1'b0; ioRd = 1'b1; #1;
      check("R3 aen blocks read", ioRdSel, 0);
      ioRd = 1'b0; aen = 1'b0;
    end

    // R2, R4, R6: memory window over both width modes
    for (int wd = 0; wd < 2; wd++) begin
      for (int l = 0; l < 128; l++) begin
        for (int s = 0; s < 8; s++) begin
          logic expHit;
          wide16 = wd[0];
          capture({3'b000, s[2:0], 14'h0}, l[6:0]);
          expHit = (l == 7'h19) && (s == 0);
          #1;
          check("R6 mem16 region", mem16Pull, (wd == 1) && (l == 7'h19));
          memRd = 1'b1; #1;
          check("R4 R2 full-range read", memRdSel, expHit && wd == 1);
          memRd = 1'b0; lowMemRd = 1'b1; #1;
          check("R4 R2 low read", memRdSel, expHit && wd == 0);
          lowMemRd = 1'b0; memWr = 1'b1; #1;
          check("R4 full-range write", memWrSel, expHit && wd == 1);
          memWr = 1'b0; lowMemWr = 1'b1; #1;
          check("R4 low write", memWrSel, expHit && wd == 0);
          lowMemWr = 1'b0;
        end
      end
    end

    // R5: boot ROM window
    for (int r = 0; r < 64; r++) begin
      wide16 = 1'b0;
      capture({r[5:0], 14'h0}, 7'h00);
      lowMemRd = 1'b1; #1;
      check("R5 rom low read 8b", romRdSel, r == 6'h3C);
      wide16 = 1'b1; #1;
      check("R5 rom low read 16b", romRdSel, r == 6'h3C);
      lowMemRd = 1'b0; memRd = 1'b1; #1;
      check("R5 rom ignores full-range", romRdSel, 0);
      memRd = 1'b0; lowMemWr = 1'b1; #1;
      check("R5 rom read only", romRdSel, 0);
      lowMemWr = 1'b0;
    end

    // R5: overlap, memory window wins
    memBaseCfg = 10'h03C;
    wide16 = 1'b0;
    capture(20'hF0000, 7'h07);
    lowMemRd = 1'b1; #1;
    check("R5 overlap mem", memRdSel, 1);
    check("R5 overlap rom", romRdSel, 0);
    wide16 = 1'b1; #1;
    check("R5 overlap rom 16b", romRdSel, 0);
    lowMemRd = 1'b0;

    // R7, R8: lane steering
    for (int wd = 0; wd < 2; wd++) begin
      for (int a0 = 0; a0 < 2; a0++) begin
        for (int hi = 0; hi < 2; hi++) begin
          logic [1:0] expLane;
          logic expOdd;
          capture(20'h00140 | 20'(a0), 7'h00);
          wide16 = wd[0]; hostHighEn = hi[0];
          #1;
          check("R8 idle lanes", laneEn, 2'b00);
          if (wd == 0) begin
            expLane = 2'b01; expOdd = a0[0];
          end else begin
            case ({a0[0], hi[0]})
              2'b00: begin expLane = 2'b01; expOdd = 0; end
              2'b01: begin expLane = 2'b11; expOdd = 0; end
              2'b10: begin expLane = 2'b01; expOdd = 1; end
              default: begin expLane = 2'b10; expOdd = 0; end
            endcase
          end
          ioRd = 1'b1; #1;
          check("R8 lanes", laneEn, expLane);
          check("R8 odd to low", oddToLow, expOdd);
          check("R7 io16", io16Pull, (wd == 1) && (a0 == 0) && (hi == 1));
          ioRd = 1'b0;
        end
      end
    end

    // R9: wait-state window
    hostHighEn = 1'b0;
    capture(20'h00140, 7'h00);
    repeat (2) @(negedge clk);
    ioRd = 1'b1; #1;
    check("R9 wait first cycle", chrdyPull, 1);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk); #1;
      check("R9 wait length", chrdyPull, k < 3);
    end
    ioRd = 1'b0;
    @(negedge clk);
    ioRd = 1'b1; #1;
    check("R9 re-arm", chrdyPull, 1);
    ioRd = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule